// File: doc/BRIEF.md
# Toggle Waveform Player

The block plays a two-level waveform on a single output pin. A producer fills a circular buffer with 32-bit period counts. Once playback starts, a counter measures each period in turn. At the end of every period the pin flips to the other level and the next count is taken from the buffer. Before any period is queued, the caller picks the level that the first segment has. When the player meets the reserved all-ones value where the next period should be, the pin stops flipping and keeps its level.

Each accepted period is stored in the next free slot, and the all-ones terminator is written into the slot after it. The buffer is therefore always terminated just past its newest entry. Playback does not start on the first push. It waits until the producer has marked its final period, or until the buffer is nearly full. The producer can then keep filling the buffer while playback runs, and it is held off whenever only a small reserve of slots is left. Playback can end in three ways: the final period completes normally, the terminator is reached before the producer has marked its last period (an underrun), or nothing makes progress for a fixed number of cycles (a stall). All three leave the block in a done state, which the next arm request leaves.

Top module: `toggle_wave_player`

## Requirements
- R1: While reset is held low on a clock edge, and afterwards until the first arm request, `wave_o`, `push_ready_o`, `busy_o`, `done_o`, `underrun_o` and `stall_o` are all 0.
- R2: An arm request in the idle or done state makes `busy_o` 1 and drives `wave_o` to `init_level_i` from the next cycle on. An arm request while `busy_o` is 1 has no effect on any output.
- R3: Before playback starts, `push_ready_o` is 1 until a period flagged with `push_last_i` is accepted. During playback it is 1 only while no final period has been accepted and the free count (DEPTH + read index − write index) mod DEPTH is greater than HEADROOM (2). In every other state it is 0.
- R4: Each accepted period is stored at the write index, and the all-ones terminator is stored at the index after it. Periods play back in push order, including across the wrap of the 128-entry buffer.
- R5: Playback starts on the accepted push that flags the final period, or on the push that brings the write index to DEPTH − HEADROOM (126), whichever comes first. If the starting push is accepted on edge E, the first flip of `wave_o` happens on edge E + 2 + P0, where P0 is the first period.
- R6: A period value N keeps `wave_o` at one level for N + 1 clock cycles. At the end of each period `wave_o` flips.
- R7: When the terminator is read at the end of a period and a final period has been accepted, `wave_o` flips one last time and then holds. `done_o` becomes 1 and `busy_o` becomes 0 on that same edge.
- R8: When the terminator is read at the end of a period and no final period has been accepted, the block enters done with `underrun_o` set to 1.
- R9: If STALL_CYCLES consecutive busy cycles pass with no accepted push, no period boundary and no playback start, the block enters done with `stall_o` set to 1 and `wave_o` unchanged.
- R10: An arm request in the done state clears `underrun_o` and `stall_o`, empties the buffer and begins a new stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| arm_i | input | 1 | Begin a new stream (ignored while busy) |
| init_level_i | input | 1 | Level of the first segment, sampled on arm |
| push_valid_i | input | 1 | A period is offered |
| push_period_i | input | 32 | Period count; all-ones is reserved |
| push_last_i | input | 1 | The offered period is the last of the stream |
| push_ready_o | output | 1 | The offered period is taken on this edge |
| wave_o | output | 1 | Waveform output |
| busy_o | output | 1 | Stream being filled or played |
| done_o | output | 1 | Stream ended; output holds |
| underrun_o | output | 1 | Terminator reached before the final period was pushed |
| stall_o | output | 1 | Stream abandoned after the progress timeout |

## Verification
The bench targets several corner cases.

- **Off-by-one in segment length.** A counter that reloads one cycle early or late would produce N-cycle or N+2-cycle segments. The directed check on the first flip, and the per-cycle model comparison, would see this.
- **Launch threshold.** A stream of 300 periods forces launch at the threshold, wraps the buffer more than once and runs into the headroom hold-off. A wrong free-slot formula or a missing terminator write would then stall the producer or end the stream early.
- **Underrun.** A full buffer with no final flag must drain into an underrun; a design that treated it as a normal end would leave the flag low.
- **Stall and ignored arm.** An idle stream and a period longer than the timeout must both stall without flipping the pin. An arm request while filling must not change the level or restart the stream.

// File: rtl/twp_pkg.sv
package twp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FILL   = 3'd1,
        ST_LAUNCH = 3'd2,
        ST_PLAY   = 3'd3,
        ST_DONE   = 3'd4
    } twp_state_e;

    typedef struct packed {
        twp_state_e st;
        logic       wave;
        logic       last_seen;
        logic       underrun;
        logic       stall;
    } twp_ctl_t;

endpackage

// File: rtl/twp_ring.sv
// Circular period store; each push also terminates the entry after it.
module twp_ring #(
    parameter  int DEPTH = 128,
    parameter  int PW    = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          push_i,
    input  logic [PW-1:0] data_i,
    input  logic          pop_i,
    output logic [PW-1:0] head_o,
    output logic [AW-1:0] wr_idx_o,
    output logic [AW-1:0] free_o
);
    localparam logic [PW-1:0] END_MARK = '1;

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
    } ptr_t;

    ptr_t          ptr_d, ptr_q;
    logic [PW-1:0] slot_q [DEPTH];
    logic [AW-1:0] wr_nxt;

    assign wr_nxt = ptr_q.wr + AW'(1);

    always_comb begin
        ptr_d = ptr_q;
        if (clr_i) begin
            ptr_d = '0;
        end else begin
            if (push_i) ptr_d.wr = wr_nxt;
            if (pop_i)  ptr_d.rd = ptr_q.rd + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    // Storage is not reset except slot 0, which must read as the terminator.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            slot_q[0] <= END_MARK;
        end else if (push_i) begin
            slot_q[ptr_q.wr] <= data_i;
            slot_q[wr_nxt]   <= END_MARK;
        end
    end

    assign head_o   = slot_q[ptr_q.rd];
    assign wr_idx_o = ptr_q.wr;
    // Power-of-two depth: modulo reduces to a plain wrap of the index width.
    assign free_o   = ptr_q.rd - ptr_q.wr;

endmodule

// File: rtl/twp_seg_timer.sv
// Up-counter with no prescale; a loaded value N yields a tick N+1 cycles later.
module twp_seg_timer #(
    parameter int PW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [PW-1:0] value_i,
    input  logic          run_i,
    output logic          tick_o
);
    typedef struct packed {
        logic [PW-1:0] cnt;
        logic [PW-1:0] per;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.cnt = '0;
            tmr_d.per = value_i;
        end else if (run_i) begin
            tmr_d.cnt = tmr_q.cnt + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign tick_o = run_i && (tmr_q.cnt == tmr_q.per);

endmodule

// File: rtl/twp_watchdog.sv
// Counts cycles of no progress while running; LIMIT of zero removes the check.
module twp_watchdog #(
    parameter  int LIMIT = 640000,
    localparam int CW    = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic kick_i,
    output logic expire_o
);
    generate
        if (LIMIT > 0) begin : g_on
            logic [CW-1:0] idle_d, idle_q;

            always_comb begin
                if (!run_i || kick_i) idle_d = '0;
                else                  idle_d = idle_q + CW'(1);
            end

            always_ff @(posedge clk) begin
                if (!rst_n) idle_q <= '0;
                else        idle_q <= idle_d;
            end

            assign expire_o = run_i && !kick_i && (idle_q == CW'(LIMIT - 1));
        end else begin : g_off
            assign expire_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/toggle_wave_player.sv
module toggle_wave_player
    import twp_pkg::*;
#(
    parameter int DEPTH        = 128,
    parameter int PW           = 32,
    parameter int HEADROOM     = 2,
    parameter int STALL_CYCLES = 640000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_i,
    input  logic          init_level_i,
    input  logic          push_valid_i,
    input  logic [PW-1:0] push_period_i,
    input  logic          push_last_i,
    output logic          push_ready_o,
    output logic          wave_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          underrun_o,
    output logic          stall_o
);
    localparam int            AW        = $clog2(DEPTH);
    localparam int            LAUNCH_AT = DEPTH - HEADROOM;
    localparam logic [PW-1:0] END_MARK  = '1;

    twp_ctl_t      ctl_d, ctl_q;
    twp_state_e    cur_st;
    logic          ring_clr, ring_pop, accept;
    logic [PW-1:0] head;
    logic [AW-1:0] wr_idx, free_cnt;
    logic [AW:0]   wr_after;
    logic          tmr_load, tmr_tick, wd_kick, wd_run, wd_expire;
    logic          head_is_end, room_ok;

    twp_ring #(.DEPTH(DEPTH), .PW(PW)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (ring_clr),
        .push_i   (accept),
        .data_i   (push_period_i),
        .pop_i    (ring_pop),
        .head_o   (head),
        .wr_idx_o (wr_idx),
        .free_o   (free_cnt)
    );

    twp_seg_timer #(.PW(PW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (tmr_load),
        .value_i (head),
        .run_i   (ctl_q.st == ST_PLAY),
        .tick_o  (tmr_tick)
    );

    twp_watchdog #(.LIMIT(STALL_CYCLES)) u_wd (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (wd_run),
        .kick_i   (wd_kick),
        .expire_o (wd_expire)
    );

    assign cur_st      = ctl_q.st;
    assign head_is_end = (head == END_MARK);
    assign room_ok     = (free_cnt > AW'(HEADROOM));
    assign wr_after    = {1'b0, wr_idx} + (AW+1)'(1);
    assign wd_run      = (ctl_q.st == ST_FILL) || (ctl_q.st == ST_LAUNCH) || (ctl_q.st == ST_PLAY);

    always_comb begin
        case (ctl_q.st)
            ST_FILL: push_ready_o = !ctl_q.last_seen;
            ST_PLAY: push_ready_o = !ctl_q.last_seen && room_ok;
            default: push_ready_o = 1'b0;
        endcase
    end

    assign accept = push_valid_i && push_ready_o;

    always_comb begin
        ctl_d    = ctl_q;
        ring_clr = 1'b0;
        ring_pop = 1'b0;
        tmr_load = 1'b0;
        wd_kick  = accept;

        case (ctl_q.st)
            ST_IDLE, ST_DONE: begin
                if (arm_i) begin
                    ctl_d.st        = ST_FILL;
                    ctl_d.wave      = init_level_i;
                    ctl_d.last_seen = 1'b0;
                    ctl_d.underrun  = 1'b0;
                    ctl_d.stall     = 1'b0;
                    ring_clr        = 1'b1;
                end
            end
            ST_FILL: begin
                if (accept) begin
                    if (push_last_i) ctl_d.last_seen = 1'b1;
                    if (push_last_i || (wr_after >= (AW+1)'(LAUNCH_AT))) ctl_d.st = ST_LAUNCH;
                end
            end
            ST_LAUNCH: begin
                // Head slot was written on the previous edge; load it now.
                tmr_load = 1'b1;
                ring_pop = 1'b1;
                wd_kick  = 1'b1;
                ctl_d.st = ST_PLAY;
            end
            ST_PLAY: begin
                if (accept && push_last_i) ctl_d.last_seen = 1'b1;
                if (tmr_tick) begin
                    wd_kick    = 1'b1;
                    ctl_d.wave = !ctl_q.wave;
                    if (head_is_end) begin
                        ctl_d.st       = ST_DONE;
                        ctl_d.underrun = !ctl_q.last_seen;
                    end else begin
                        tmr_load = 1'b1;
                        ring_pop = 1'b1;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase

        if (wd_expire) begin
            ctl_d.st    = ST_DONE;
            ctl_d.stall = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign wave_o     = ctl_q.wave;
    assign busy_o     = wd_run;
    assign done_o     = (ctl_q.st == ST_DONE);
    assign underrun_o = ctl_q.underrun;
    assign stall_o    = ctl_q.stall;

endmodule

// File: rtl/twp_checker.sv
module twp_checker
    import twp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       arm_i,
    input logic       init_level_i,
    input logic       push_valid_i,
    input logic       push_last_i,
    input logic       push_ready_o,
    input logic       wave_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       underrun_o,
    input logic       stall_o,
    input twp_state_e st_i,
    input logic       tick_i
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !push_ready_o);

    assert_arm_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_i == ST_FILL && arm_i) |=> (wave_o == $past(wave_o)) && busy_o);

    assert_hold_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid_i && push_ready_o && push_last_i) |=> !push_ready_o);

    assert_steady_between_ticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_i == ST_PLAY && !tick_i) |=> $stable(wave_o));

    assert_flip_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_i == ST_PLAY && tick_i) |=> (wave_o != $past(wave_o)));

    assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !arm_i) |=> (done_o && $stable(wave_o)));

    assert_underrun_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun_o) |-> done_o);

    assert_stall_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_o) |-> (done_o && !underrun_o));

    assert_rearm_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && arm_i) |=> (busy_o && !underrun_o && !stall_o && wave_o == $past(init_level_i)));

endmodule

bind toggle_wave_player twp_checker u_twp_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .arm_i        (arm_i),
    .init_level_i (init_level_i),
    .push_valid_i (push_valid_i),
    .push_last_i  (push_last_i),
    .push_ready_o (push_ready_o),
    .wave_o       (wave_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .underrun_o   (underrun_o),
    .stall_o      (stall_o),
    .st_i         (cur_st),
    .tick_i       (tmr_tick)
);

// File: tb/toggle_wave_player_tb_top.sv
`timescale 1ns/1ps
module toggle_wave_player_tb_top;
    localparam int STALL = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm_i = 1'b0;
    logic        init_level_i = 1'b0;
    logic        push_valid_i = 1'b0;
    logic [31:0] push_period_i = '0;
    logic        push_last_i = 1'b0;
    logic        push_ready_o, wave_o, busy_o, done_o, underrun_o, stall_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit compare_on = 1'b0;

    always #5 clk = ~clk;

    toggle_wave_player #(.STALL_CYCLES(STALL)) dut_i (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .init_level_i(init_level_i),
        .push_valid_i(push_valid_i), .push_period_i(push_period_i), .push_last_i(push_last_i),
        .push_ready_o(push_ready_o), .wave_o(wave_o), .busy_o(busy_o), .done_o(done_o),
        .underrun_o(underrun_o), .stall_o(stall_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int      m_st;            // 0 idle, 1 fill, 2 launch, 3 play, 4 done
    bit      m_wave, m_last, m_und, m_stl;
    longint  m_q[$];
    int      m_wr, m_rd, m_wd;
    longint  m_rem;

    function automatic bit m_ready();
        int fr;
        fr = (128 + (m_rd % 128) - (m_wr % 128)) % 128;
        if (m_st == 1) return !m_last;
        if (m_st == 3) return !m_last && (fr > 2);
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        bit acc, kick, run;
        if (!rst_n) begin
            m_st = 0; m_wave = 0; m_last = 0; m_und = 0; m_stl = 0;
            m_q.delete(); m_wr = 0; m_rd = 0; m_wd = 0; m_rem = 0;
        end else begin
            acc  = push_valid_i && m_ready();
            kick = acc;
            run  = (m_st == 1) || (m_st == 2) || (m_st == 3);
            case (m_st)
                0, 4: if (arm_i) begin
                    m_st = 1; m_wave = init_level_i; m_last = 0; m_und = 0; m_stl = 0;
                    m_q.delete(); m_wr = 0; m_rd = 0;
                end
                1: if (acc) begin
                    m_q.push_back(longint'(push_period_i)); m_wr++;
                    if (push_last_i) m_last = 1;
                    if (push_last_i || m_wr >= 126) m_st = 2;
                end
                2: begin
                    m_rem = m_q.pop_front(); m_rd++; m_st = 3; kick = 1;
                end
                3: begin
                    if (m_rem == 0) begin
                        kick = 1; m_wave = !m_wave;
                        if (m_q.size() == 0) begin m_st = 4; m_und = !m_last; end
                        else begin m_rem = m_q.pop_front(); m_rd++; end
                    end else m_rem--;
                    if (acc) begin
                        m_q.push_back(longint'(push_period_i)); m_wr++;
                        if (push_last_i) m_last = 1;
                    end
                end
                default: ;
            endcase
            if (run) begin
                if (kick) m_wd = 0;
                else if (m_wd == STALL - 1) begin m_st = 4; m_stl = 1; m_wd = 0; end
                else m_wd++;
            end else m_wd = 0;
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && compare_on) begin
            chk(wave_o == m_wave, "R4 R6 wave", wave_o, m_wave);
            chk(push_ready_o == m_ready(), "R3 ready", push_ready_o, m_ready());
            chk(busy_o == (m_st >= 1 && m_st <= 3), "R2 busy", busy_o, (m_st >= 1 && m_st <= 3));
            chk(done_o == (m_st == 4), "R7 done", done_o, (m_st == 4));
            chk(underrun_o == m_und, "R8 underrun", underrun_o, m_und);
            chk(stall_o == m_stl, "R9 stall", stall_o, m_stl);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic do_arm(input bit lvl);
        arm_i = 1'b1; init_level_i = lvl;
        @(negedge clk);
        arm_i = 1'b0;
    endtask

    task automatic push(input int p, input bit last);
        bit taken;
        push_valid_i = 1'b1; push_period_i = p; push_last_i = last;
        for (int g = 0; g < 5000; g++) begin
            taken = push_ready_o;
            @(negedge clk);
            if (taken) break;
        end
        push_valid_i = 1'b0; push_last_i = 1'b0;
    endtask

    task automatic wait_done();
        for (int g = 0; g < 20000 && !done_o; g++) @(negedge clk);
    endtask

    initial begin
        int k;
        repeat (4) @(negedge clk);
        chk({wave_o, push_ready_o, busy_o, done_o, underrun_o, stall_o} == 6'b0, "R1 in reset",
            {wave_o, push_ready_o, busy_o, done_o, underrun_o, stall_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({wave_o, push_ready_o, busy_o, done_o} == 4'b0, "R1 idle after reset",
            {wave_o, push_ready_o, busy_o, done_o}, 0);
        compare_on = 1'b1;

        // Short stream, arm ignored while filling.
        do_arm(1'b1);
        chk(busy_o && wave_o, "R2 arm sets level", {busy_o, wave_o}, 3);
        push(2, 0);
        push(0, 0);
        arm_i = 1'b1; init_level_i = 1'b0;
        @(negedge clk);
        arm_i = 1'b0;
        chk(wave_o == 1'b1 && busy_o, "R2 arm ignored while busy", wave_o, 1);
        push(5, 1);
        chk(push_ready_o == 1'b0, "R3 ready low after final", push_ready_o, 0);
        wait_done();
        chk(done_o && wave_o == 1'b0 && !underrun_o, "R7 three flips then hold", wave_o, 0);

        // First flip timing: accept on edge E, flip on edge E+2+P.
        do_arm(1'b0);
        push(4, 1);
        k = 0;
        while (wave_o == 1'b0 && k < 50) begin @(negedge clk); k++; end
        chk(k == 6, "R5 R6 first segment timing", k, 6);
        chk(done_o && !busy_o, "R7 done with last flip", done_o, 1);
        repeat (5) @(negedge clk);
        chk(wave_o == 1'b1, "R7 level held", wave_o, 1);

        // Long stream: threshold launch, headroom hold-off, wrap.
        do_arm(1'b0);
        for (int i = 0; i < 300; i++) push((i * 7) % 4, i == 299);
        wait_done();
        chk(done_o && !underrun_o && !stall_o, "R4 R5 long stream ends cleanly", underrun_o, 0);
        chk(wave_o == 1'b0, "R4 even flip count", wave_o, 0);

        // Underrun: full buffer with no final flag.
        do_arm(1'b1);
        for (int i = 0; i < 126; i++) push(i % 2, 0);
        wait_done();
        chk(underrun_o == 1'b1 && !stall_o, "R8 underrun raised", underrun_o, 1);

        // Re-arm clears flags; then an idle fill stalls.
        do_arm(1'b0);
        chk(!underrun_o && !stall_o && busy_o, "R10 re-arm clears flags", {underrun_o, stall_o}, 0);
        wait_done();
        chk(stall_o == 1'b1, "R9 stall while filling", stall_o, 1);

        // A period longer than the timeout stalls without flipping.
        do_arm(1'b0);
        push(400, 1);
        wait_done();
        chk(stall_o && wave_o == 1'b0, "R9 stall during long period", {stall_o, wave_o}, 2);

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule